// File: doc/BRIEF.md
# Shared Timebase Counter with Per-Target Compare Interrupts

This block keeps one free-running counter that every processor target in a cluster shares as its timebase. The counter width is set at build time as 32 plus four times a width field (1 to 8), and a configuration register reports that field. A halt bit in the same register freezes counting. Software reads the count as two separate 32-bit words, a low word and a high word. No snapshot is taken, so the reader must repeat the high-word read to detect a carry that occurred between the two reads.

Each target owns a 64-bit compare value that is written as two 32-bit halves. When the counter equals a target's compare value, that target's interrupt line asserts. It stays asserted until software writes either half of that target's compare value. Every register access carries the number of the requesting target. A local window always reaches the requester's own compare halves. An other-target window reaches the compare halves of whichever target the requester's select register names.

Top module: `gcnt_timer`

## Requirements
- R1: After reset the counter is halted at zero, all compare values are all ones, no interrupt is pending and `reg_rdata` is zero. The configuration word (address 0) reads 0x00030401 with the defaults: halt in bit 0, width field in bits 11:8, number of targets minus one in bits 19:16.
- R2: Address 1 reads count bits 31:0 and address 2 reads the bits above 31, zero-extended. Bits above the configured width read as zero, and the counter wraps to zero at its configured width.
- R3: Writing address 0 sets or clears only the halt bit (bit 0); the width and target fields are read-only. While the counter is not halted it increments by one every cycle. The first increment comes on the edge after the clear is written, and the last one on the edge where halt is written.
- R4: Writes to addresses 1 and 2 load the counter only while it is halted; while it runs they are ignored.
- R5: Incrementing a low word of 0xFFFFFFFF carries into the high word.
- R6: Addresses 4 and 5 access the low and high halves of the compare value of the target named on `reg_src`.
- R7: Address 6 holds a per-requester 8-bit select. Addresses 8 and 9 access the low and high compare halves of the target that the requester's select names.
- R8: When a requester's select is not below the number of targets, writes to addresses 8 and 9 are dropped and reads return zero.
- R9: A target's interrupt rises on the edge after the counter equals its compare value and then stays set while the count moves on.
- R10: A write to either compare half of a target clears its interrupt on that edge. A write in the same cycle as a match wins over the match.
- R11: `reg_rdata` loads on the edge where `reg_rd` is high and holds otherwise. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address |
| reg_src | input | $clog2(NUM_TGT) | Number of the requesting target |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| cmp_irq | output | NUM_TGT | Per-target compare interrupt |

## Verification
A compare-register write and a compare match can fall in the same cycle, and so can the clearing of a pending interrupt and a fresh match. The bench loads the counter ten counts below a target's compare value and restarts it. It then times a new compare write so that it lands on exactly the edge where the match would set the interrupt. The check is that the line stays low on that edge and afterwards. A separate run with no write checks that the same timing gives a rise on exactly that edge, so both sides of the race are judged against the same cycle count.

// File: rtl/gcnt_pkg.sv
`timescale 1ns/1ps
package gcnt_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int SEL_W  = 8;

    // Configuration word layout
    localparam int CFG_HALT_BIT = 0;
    localparam int CFG_WID_LSB  = 8;
    localparam int CFG_TGT_LSB  = 16;

    typedef enum logic [ADDR_W-1:0] {
        RA_CFG     = 4'd0,
        RA_CNT_LO  = 4'd1,
        RA_CNT_HI  = 4'd2,
        RA_CMP_LO  = 4'd4,
        RA_CMP_HI  = 4'd5,
        RA_OSEL    = 4'd6,
        RA_OCMP_LO = 4'd8,
        RA_OCMP_HI = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic cfg;
        logic cnt_lo;
        logic cnt_hi;
        logic cmp_lo;
        logic cmp_hi;
        logic osel;
        logic ocmp_lo;
        logic ocmp_hi;
    } acc_sel_t;

    function automatic int cnt_width(input int field);
        return 32 + 4 * field;
    endfunction

    function automatic acc_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        acc_sel_t s;
        s = '0;
        case (a)
            RA_CFG:     s.cfg     = 1'b1;
            RA_CNT_LO:  s.cnt_lo  = 1'b1;
            RA_CNT_HI:  s.cnt_hi  = 1'b1;
            RA_CMP_LO:  s.cmp_lo  = 1'b1;
            RA_CMP_HI:  s.cmp_hi  = 1'b1;
            RA_OSEL:    s.osel    = 1'b1;
            RA_OCMP_LO: s.ocmp_lo = 1'b1;
            RA_OCMP_HI: s.ocmp_hi = 1'b1;
            default:    s         = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gcnt_counter.sv
`timescale 1ns/1ps
module gcnt_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt_wr,
    input  logic             halt_in,
    input  logic             lo_wr,
    input  logic             hi_wr,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] count,
    output logic             halted
);
    localparam int HI_W = CNT_W - 32;

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            halted <= 1'b1;
        end else begin
            if (halt_wr)
                halted <= halt_in;
            if (halted) begin
                if (lo_wr)
                    count[31:0] <= wdata;
                if (hi_wr)
                    count[CNT_W-1:32] <= wdata[HI_W-1:0];
            end else begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/gcnt_cmp_slot.sv
`timescale 1ns/1ps
module gcnt_cmp_slot (
    input  logic        clk,
    input  logic        rst,
    input  logic        lo_wr,
    input  logic        hi_wr,
    input  logic [31:0] wdata,
    input  logic [63:0] cnt_ext,
    output logic [63:0] cmp,
    output logic        match,
    output logic        irq
);
    assign match = (cnt_ext == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp <= '1;
            irq <= 1'b0;
        end else begin
            if (lo_wr)
                cmp[31:0] <= wdata;
            if (hi_wr)
                cmp[63:32] <= wdata;
            if (lo_wr || hi_wr)
                irq <= 1'b0;
            else if (match)
                irq <= 1'b1;
        end
    end

endmodule

// File: rtl/gcnt_timer.sv
`timescale 1ns/1ps
module gcnt_timer
    import gcnt_pkg::*;
#(
    parameter int NUM_TGT   = 4,
    parameter int CNT_FIELD = 4,
    localparam int TGT_W    = $clog2(NUM_TGT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [TGT_W-1:0]   reg_src,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_TGT-1:0] cmp_irq
);
    localparam int CNT_W = cnt_width(CNT_FIELD);
    localparam int HI_W  = CNT_W - 32;

    acc_sel_t           acc;
    logic [CNT_W-1:0]   cnt_value;
    logic               cnt_halt;
    logic               cnt_lo_wr;
    logic               cnt_hi_wr;
    logic               halt_wr;
    logic [63:0]        cnt_ext;
    logic [SEL_W-1:0]   osel_q [NUM_TGT];
    logic [SEL_W-1:0]   osel_cur;
    logic               oth_ok;
    logic [TGT_W-1:0]   oth_idx;
    logic [63:0]        cmp_val [NUM_TGT];
    logic [NUM_TGT-1:0] slot_match;
    logic [NUM_TGT-1:0] slot_wr;
    logic [NUM_TGT-1:0] slot_lo_wr;
    logic [NUM_TGT-1:0] slot_hi_wr;
    logic [DATA_W-1:0]  rd_mux;

    always_comb acc = decode_addr(reg_addr);

    assign halt_wr   = reg_wr && acc.cfg;
    assign cnt_lo_wr = reg_wr && acc.cnt_lo;
    assign cnt_hi_wr = reg_wr && acc.cnt_hi;

    gcnt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .halt_wr (halt_wr),
        .halt_in (reg_wdata[CFG_HALT_BIT]),
        .lo_wr   (cnt_lo_wr),
        .hi_wr   (cnt_hi_wr),
        .wdata   (reg_wdata),
        .count   (cnt_value),
        .halted  (cnt_halt)
    );

    always_comb begin
        cnt_ext = '0;
        cnt_ext[CNT_W-1:0] = cnt_value;
    end

    // Per-requester select for the other-target window
    assign osel_cur = osel_q[reg_src];
    assign oth_ok   = (osel_cur < SEL_W'(NUM_TGT));
    assign oth_idx  = osel_cur[TGT_W-1:0];

    always_ff @(posedge clk) begin
        for (int t = 0; t < NUM_TGT; t++) begin
            if (rst)
                osel_q[t] <= '0;
            else if (reg_wr && acc.osel && reg_src == TGT_W'(t))
                osel_q[t] <= reg_wdata[SEL_W-1:0];
        end
    end

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_slot
        logic own_hit;
        logic oth_hit;
        assign own_hit = (reg_src == TGT_W'(t));
        assign oth_hit = oth_ok && (oth_idx == TGT_W'(t));
        assign slot_lo_wr[t] = reg_wr && ((acc.cmp_lo && own_hit) || (acc.ocmp_lo && oth_hit));
        assign slot_hi_wr[t] = reg_wr && ((acc.cmp_hi && own_hit) || (acc.ocmp_hi && oth_hit));
        assign slot_wr[t]    = slot_lo_wr[t] || slot_hi_wr[t];

        gcnt_cmp_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .lo_wr   (slot_lo_wr[t]),
            .hi_wr   (slot_hi_wr[t]),
            .wdata   (reg_wdata),
            .cnt_ext (cnt_ext),
            .cmp     (cmp_val[t]),
            .match   (slot_match[t]),
            .irq     (cmp_irq[t])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (acc.cfg) begin
            rd_mux[CFG_HALT_BIT]     = cnt_halt;
            rd_mux[CFG_WID_LSB +: 4] = 4'(CNT_FIELD);
            rd_mux[CFG_TGT_LSB +: 4] = 4'(NUM_TGT - 1);
        end else if (acc.cnt_lo) begin
            rd_mux = cnt_value[31:0];
        end else if (acc.cnt_hi) begin
            rd_mux[HI_W-1:0] = cnt_value[CNT_W-1:32];
        end else if (acc.cmp_lo) begin
            rd_mux = cmp_val[reg_src][31:0];
        end else if (acc.cmp_hi) begin
            rd_mux = cmp_val[reg_src][63:32];
        end else if (acc.osel) begin
            rd_mux[SEL_W-1:0] = osel_cur;
        end else if (acc.ocmp_lo && oth_ok) begin
            rd_mux = cmp_val[oth_idx][31:0];
        end else if (acc.ocmp_hi && oth_ok) begin
            rd_mux = cmp_val[oth_idx][63:32];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end

endmodule

// File: rtl/gcnt_timer_chk.sv
`timescale 1ns/1ps
module gcnt_timer_chk #(
    parameter int NUM_TGT = 4,
    parameter int CNT_W   = 48
) (
    input logic               clk,
    input logic               rst,
    input logic [CNT_W-1:0]   cnt_value,
    input logic               cnt_halt,
    input logic               cnt_lo_wr,
    input logic               cnt_hi_wr,
    input logic [NUM_TGT-1:0] slot_match,
    input logic [NUM_TGT-1:0] slot_wr,
    input logic [NUM_TGT-1:0] cmp_irq,
    input logic               reg_rd,
    input logic [3:0]         reg_addr,
    input logic [31:0]        reg_rdata
);
    localparam int HI_W = CNT_W - 32;
    localparam logic [31:0] ABOVE_MASK = (HI_W >= 32) ? 32'h0 : ~((32'h1 << HI_W) - 32'h1);

    // R3
    run_step_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_halt |=> cnt_value == CNT_W'($past(cnt_value) + 1'b1));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_halt && !cnt_lo_wr && !cnt_hi_wr) |=> $stable(cnt_value));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));

    // R2
    hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 4'd2) |=> (reg_rdata & ABOVE_MASK) == 32'h0);

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        // R9
        irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(cmp_irq[t]) |-> $past(slot_match[t]));

        // R9
        irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (cmp_irq[t] && !slot_wr[t]) |=> cmp_irq[t]);

        // R10
        irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
            slot_wr[t] |=> !cmp_irq[t]);
    end

endmodule

bind gcnt_timer gcnt_timer_chk #(.NUM_TGT(NUM_TGT), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_value  (cnt_value),
    .cnt_halt   (cnt_halt),
    .cnt_lo_wr  (cnt_lo_wr),
    .cnt_hi_wr  (cnt_hi_wr),
    .slot_match (slot_match),
    .slot_wr    (slot_wr),
    .cmp_irq    (cmp_irq),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata)
);

// File: tb/test_gcnt_timer.sv
`timescale 1ns/1ps
module test_gcnt_timer;

    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic        reg_rd;
    logic [3:0]  reg_addr;
    logic [1:0]  reg_src;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [NT-1:0] cmp_irq;

    int n_run  = 0;
    int n_fail = 0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    gcnt_timer #(.NUM_TGT(NT), .CNT_FIELD(4)) i_gcnt_timer (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_src   (reg_src),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cmp_irq   (cmp_irq)
    );

    // Monitor: pops the expected read result the cycle after a read strobe
    logic rd_seen = 1'b0;
    always @(posedge clk) rd_seen <= reg_rd && !rst;

    always @(negedge clk) begin
        if (rd_seen) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected read result actual=%h expected=none", reg_rdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (reg_rdata !== e.val) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, reg_rdata, e.val);
                end
            end
        end
    end

    task automatic do_wr(input logic [3:0] a, input int s, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_src = 2'(s); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [3:0] a, input int s, input logic [31:0] e, input string tag);
        exp_t x;
        x.val = e; x.tag = tag;
        exp_q.push_back(x);
        reg_rd = 1'b1; reg_addr = a; reg_src = 2'(s);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
        n_run++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, e);
        end
    endtask

    task automatic run_ticks(input int n);
        do_wr(4'd0, 0, 32'h0);
        repeat (n) @(negedge clk);
        do_wr(4'd0, 0, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0;
        reg_addr = '0; reg_src = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(32'(cmp_irq), 32'h0, "R1 irq after reset");
        chk(reg_rdata, 32'h0, "R1 rdata after reset");
        do_rd(4'd0, 0, 32'h0003_0401, "R1 cfg word");
        do_rd(4'd1, 0, 32'h0, "R1 count low");
        do_rd(4'd4, 0, 32'hFFFF_FFFF, "R1 cmp low t0");
        do_rd(4'd5, 3, 32'hFFFF_FFFF, "R1 cmp high t3");

        // R2 upper bits zero, wrap at width; R3 fields read-only while running
        do_wr(4'd2, 0, 32'hFFFF_FFFF);
        do_rd(4'd2, 0, 32'h0000_FFFF, "R2 high word masked");
        do_wr(4'd1, 0, 32'hFFFF_FFFE);
        do_wr(4'd0, 0, 32'hFFFF_FFF0);
        do_rd(4'd0, 0, 32'h0003_0400, "R3 cfg fields kept, halt clear");
        @(negedge clk);
        do_wr(4'd0, 0, 32'h1);
        do_rd(4'd2, 0, 32'h0, "R2 wrap high");
        do_rd(4'd1, 0, 32'h1, "R2 wrap low");

        // R5 carry, R3 exact increments (29 idle cycles -> 30 counts)
        do_wr(4'd1, 0, 32'hFFFF_FFF0);
        do_wr(4'd2, 0, 32'h5);
        run_ticks(29);
        do_rd(4'd2, 0, 32'h6, "R5 carry into high");
        do_rd(4'd1, 0, 32'hE, "R5 low after carry");
        do_rd(4'd0, 0, 32'h0003_0401, "R3 halted again");

        // R4 counter writes while running are ignored
        do_wr(4'd1, 0, 32'h500);
        do_wr(4'd2, 0, 32'h0);
        do_wr(4'd0, 0, 32'h0);
        do_wr(4'd1, 0, 32'h0);
        do_wr(4'd2, 0, 32'h77);
        do_wr(4'd0, 0, 32'h1);
        do_rd(4'd1, 0, 32'h503, "R4 low write ignored");
        do_rd(4'd2, 0, 32'h0, "R4 high write ignored");

        // R6 local window per requester
        for (int t = 0; t < NT; t++) begin
            do_wr(4'd4, t, 32'h1000 + t);
            do_wr(4'd5, t, 32'(t));
        end
        for (int t = 0; t < NT; t++) begin
            do_rd(4'd4, t, 32'h1000 + t, "R6 local cmp low");
            do_rd(4'd5, t, 32'(t), "R6 local cmp high");
        end

        // R7 other-target window
        do_wr(4'd6, 0, 32'h2);
        do_rd(4'd6, 0, 32'h2, "R7 select t0");
        do_rd(4'd6, 1, 32'h0, "R7 select t1 untouched");
        do_wr(4'd8, 0, 32'hCAFE_0000);
        do_rd(4'd4, 2, 32'hCAFE_0000, "R7 other write seen locally");
        do_rd(4'd9, 0, 32'h2, "R7 other read high");

        // R8 out-of-range select
        do_wr(4'd6, 1, 32'h9);
        do_wr(4'd8, 1, 32'h0000_DEAD);
        do_rd(4'd8, 1, 32'h0, "R8 other read zero");
        do_rd(4'd4, 0, 32'h1000, "R8 t0 unchanged");
        do_rd(4'd4, 1, 32'h1001, "R8 t1 unchanged");
        do_rd(4'd4, 2, 32'hCAFE_0000, "R8 t2 unchanged");
        do_rd(4'd4, 3, 32'h1003, "R8 t3 unchanged");

        // R9 / R10 match for each target
        for (int t = 0; t < NT; t++) begin
            do_wr(4'd5, t, 32'h0);
            do_wr(4'd4, t, 32'h100);
            do_wr(4'd2, 0, 32'h0);
            do_wr(4'd1, 0, 32'h100 - 10);
            do_wr(4'd0, 0, 32'h0);
            repeat (10) @(negedge clk);
            chk(32'(cmp_irq), 32'h0, "R9 no irq before match edge");
            @(negedge clk);
            chk(32'(cmp_irq), 32'(1 << t), "R9 irq on match edge");
            do_wr(4'd0, 0, 32'h1);
            repeat (3) @(negedge clk);
            chk(32'(cmp_irq), 32'(1 << t), "R9 irq stays pending");
            do_wr(4'd5, t, 32'hFFFF_FFFF);
            chk(32'(cmp_irq), 32'h0, "R10 compare write clears");
        end

        // R10 compare write in the same cycle as the match
        do_wr(4'd5, 1, 32'h0);
        do_wr(4'd4, 1, 32'h200);
        do_wr(4'd1, 0, 32'h200 - 10);
        do_wr(4'd0, 0, 32'h0);
        repeat (10) @(negedge clk);
        do_wr(4'd4, 1, 32'h5000);
        chk(32'(cmp_irq), 32'h0, "R10 write beats same-cycle match");
        repeat (3) @(negedge clk);
        chk(32'(cmp_irq), 32'h0, "R10 no late rise");
        do_wr(4'd0, 0, 32'h1);

        // R11 unmapped read and hold
        do_rd(4'd3, 0, 32'h0, "R11 unmapped reads zero");
        do_rd(4'd0, 0, 32'h0003_0401, "R11 cfg read");
        repeat (3) @(negedge clk);
        chk(reg_rdata, 32'h0003_0401, "R11 rdata holds");

        repeat (2) @(negedge clk);
        chk(32'(exp_q.size()), 32'h0, "R11 all reads answered");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule